// File: doc/BRIEF.md
# Serial Modem Handshake Status and Control

This block holds the modem-control registers of one serial channel. It watches three asynchronous handshake inputs from the line (clear-to-send, data-set-ready and carrier-detect) and brings each one into the clock domain through a two-flop synchronizer. It shows the live levels of all three in a status register. It records chosen transitions in sticky flags. Each flag is armed by a single edge direction and only while a transmitter or receiver condition holds. When a set flag also has its enable bit set, the block raises an interrupt request. Software clears a flag by writing a 1 to its bit.

A control register drives the data-terminal-ready output directly. The request-to-send output is held by a two-state machine. In state `RTS_RELEASED`, a control write with the request bit set moves it to `RTS_HELD` (transition *assert*). In `RTS_HELD`, software writes cannot lower the output. Only the transmitter's drained pulse moves it back to `RTS_RELEASED` (transition *release*). The request bit read back from the control register always reflects the machine's state.

The bus is a single-cycle 8-bit register port. A write happens on a clock edge while `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `modem_status_ctl`

## Requirements
- R1: After reset, the status, control and interrupt-enable registers read 0x00, and `dtr_out`, `rts_out` and `irq` are low.
- R2: The status register at offset 0x10 shows the synchronized clear-to-send, data-set-ready and carrier-detect levels at bits 4, 3 and 2 (1 = active). The levels appear two clock edges after the input changes.
- R3: Status bit 7 becomes set when clear-to-send goes from active to inactive while the request machine is in `RTS_HELD` and `tx_enable` is high.
- R4: Status bit 6 becomes set when data-set-ready goes from inactive to active while `rx_reset` is low.
- R5: Status bit 5 becomes set when carrier-detect goes from active to inactive while `rx_reset` is low.
- R6: A transition flag is not set by the opposite edge, and it is not set while its qualifier is false.
- R7: Writing offset 0x10 clears each flag whose bit (7, 6 or 5) is written as 1. Flags written as 0 and the level bits are unchanged.
- R8: `irq` is high exactly while some flag is set and the bit at the same position (7, 6 or 5) of the interrupt-enable register at offset 0x15 is 1. The interrupt-enable register reads back as written.
- R9: Writing the control register at offset 0x11 with bit 7 = 1 while released asserts `rts_out`. While held, writing bit 7 = 0 leaves `rts_out` high. Bit 7 of a control read equals `rts_out`.
- R10: A one-cycle `tx_drained` pulse while held deasserts `rts_out` and clears control bit 7.
- R11: Every control write copies bit 6 to `dtr_out`. Control bits 6..0 read back as last written.
- R12: Offsets other than 0x10, 0x11 and 0x15 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cts_in | input | 1 | Clear-to-send level, 1 = active, asynchronous |
| dsr_in | input | 1 | Data-set-ready level, 1 = active, asynchronous |
| dcd_in | input | 1 | Carrier-detect level, 1 = active, asynchronous |
| tx_enable | input | 1 | Transmitter enabled |
| rx_reset | input | 1 | Receiver held in reset |
| tx_drained | input | 1 | Pulse: transmitter finished with its FIFO empty |
| dtr_out | output | 1 | Data-terminal-ready output |
| rts_out | output | 1 | Request-to-send output |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest case to reach is the clear-to-send flag. It needs three conditions at once: the request machine must already be in `RTS_HELD`, the transmitter must be enabled, and clear-to-send must fall after it was seen high through the synchronizer. The stimulus first raises clear-to-send and waits out the synchronizer. It then asserts the request through a control write and enables the transmitter. Only after that does it drop the line. A matching run with the transmitter disabled shows that the same edge leaves the flag clear.

// File: rtl/modem_pkg.sv
package modem_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 8;
    localparam int N_LINES  = 3;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h11;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 5'h15;

    // line index: 2 = clear-to-send, 1 = data-set-ready, 0 = carrier-detect
    localparam int LINE_CTS = 2;
    localparam int LINE_DSR = 1;
    localparam int LINE_DCD = 0;

    localparam int FLAG_LSB  = 5;   // flags at status bits 7..5
    localparam int LEVEL_LSB = 2;   // levels at status bits 4..2
    localparam int CTRL_RTS  = 7;
    localparam int CTRL_DTR  = 6;

    typedef enum logic {
        RTS_RELEASED = 1'b0,
        RTS_HELD     = 1'b1
    } rts_state_t;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] level_prev
);
    logic [WIDTH-1:0] meta_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[i]     <= 1'b0;
                level[i]      <= 1'b0;
                level_prev[i] <= 1'b0;
            end else begin
                meta_q[i]     <= din[i];
                level[i]      <= meta_q[i];
                level_prev[i] <= level[i];
            end
        end
    end
endmodule

// File: rtl/modem_flag_cell.sv
module modem_flag_cell #(
    parameter bit RISE_ARMS = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic level_prev,
    input  logic qual,
    input  logic clr,
    output logic flag
);
    logic edge_seen;

    if (RISE_ARMS) begin : g_rise
        assign edge_seen = level & ~level_prev;
    end else begin : g_fall
        assign edge_seen = ~level & level_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                flag <= 1'b0;
        else if (edge_seen & qual) flag <= 1'b1;
        else if (clr)              flag <= 1'b0;
    end

    // R6: a flag never rises while its qualifier was false
    a_r6_no_unqualified_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(qual));
endmodule

// File: rtl/modem_rts_fsm.sv
module modem_rts_fsm
    import modem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_write,
    input  logic req_bit,
    input  logic drained,
    output logic rts_out,
    output logic held
);
    rts_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RTS_RELEASED: if (req_write && req_bit) state_d = RTS_HELD;
            RTS_HELD:     if (drained)              state_d = RTS_RELEASED;
            default:      state_d = RTS_RELEASED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RTS_RELEASED;
        else        state_q <= state_d;
    end

    always_comb begin
        held    = (state_q == RTS_HELD);
        rts_out = held;
    end

    // R9: software cannot lower the request while held
    a_r9_rts_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rts_out) && !$past(drained)) |-> rts_out);
    // R10: drain pulse while held releases the output
    a_r10_release_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rts_out) && $past(drained)) |-> !rts_out);
endmodule

// File: rtl/modem_status_ctl.sv
module modem_status_ctl
    import modem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cts_in,
    input  logic              dsr_in,
    input  logic              dcd_in,
    input  logic              tx_enable,
    input  logic              rx_reset,
    input  logic              tx_drained,
    output logic              dtr_out,
    output logic              rts_out,
    output logic              irq
);
    localparam logic [N_LINES-1:0] RISE_MASK = 3'b010; // only data-set-ready arms on rise

    logic [N_LINES-1:0] lvl, lvl_prev, qual, flags, clr;
    logic [DATA_W-1:0]  ien_q;
    logic [CTRL_DTR:0]  ctrl_q;
    logic               rts_held;
    logic               wr_status, wr_ctrl, wr_ien;

    assign wr_status = bus_wr && (bus_addr == OFS_STATUS);
    assign wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_ien    = bus_wr && (bus_addr == OFS_IEN);

    modem_sync #(.WIDTH(N_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({cts_in, dsr_in, dcd_in}),
        .level(lvl), .level_prev(lvl_prev)
    );

    always_comb begin
        qual[LINE_CTS] = rts_held & tx_enable;
        qual[LINE_DSR] = ~rx_reset;
        qual[LINE_DCD] = ~rx_reset;
        clr = wr_status ? bus_wdata[FLAG_LSB +: N_LINES] : '0;
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_flag
        modem_flag_cell #(.RISE_ARMS(RISE_MASK[i])) u_cell (
            .clk(clk), .rst_n(rst_n),
            .level(lvl[i]), .level_prev(lvl_prev[i]),
            .qual(qual[i]), .clr(clr[i]), .flag(flags[i])
        );
    end

    modem_rts_fsm u_rts (
        .clk(clk), .rst_n(rst_n),
        .req_write(wr_ctrl), .req_bit(bus_wdata[CTRL_RTS]),
        .drained(tx_drained), .rts_out(rts_out), .held(rts_held)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ien_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_DTR:0];
            if (wr_ien)  ien_q  <= bus_wdata;
        end
    end

    assign dtr_out = ctrl_q[CTRL_DTR];
    assign irq     = |(flags & ien_q[FLAG_LSB +: N_LINES]);

    always_comb begin
        unique case (bus_addr)
            OFS_STATUS: bus_rdata = {flags, lvl, 2'b00};
            OFS_CTRL:   bus_rdata = {rts_held, ctrl_q};
            OFS_IEN:    bus_rdata = ien_q;
            default:    bus_rdata = '0;
        endcase
    end

    // R11: terminal-ready follows the last control write
    a_r11_dtr_follow: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_ctrl) |-> (dtr_out == $past(bus_wdata[CTRL_DTR])));
    // R3: clear-to-send flag only armed while the request is held
    a_r3_cts_needs_rts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[LINE_CTS]) |-> $past(rts_out));
endmodule

// File: tb/tb_modem_status_ctl.sv
`timescale 1ns/1ps
module tb_modem_status_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic cts_in = 0, dsr_in = 0, dcd_in = 0;
    logic tx_enable = 0, rx_reset = 0, tx_drained = 0;
    logic dtr_out, rts_out, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    modem_status_ctl dut (.*);

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(5'h10, d); check("R1 status", d, 8'h00);
        rd(5'h11, d); check("R1 ctrl", d, 8'h00);
        rd(5'h15, d); check("R1 ien", d, 8'h00);
        check("R1 outputs", {dtr_out, rts_out, irq}, 3'b000);
    endtask

    task automatic t_levels();
        logic [7:0] d;
        cts_in = 1; dcd_in = 1; rx_reset = 1;
        step(4);
        rd(5'h10, d); check("R2 cts+dcd levels", d, 8'h14);
        dsr_in = 1; cts_in = 0;
        step(4);
        rd(5'h10, d); check("R2 dsr level, R6 cts unqualified", d, 8'h0C);
        dsr_in = 0; dcd_in = 0;
        step(4);
        rd(5'h10, d); check("R6 dcd fall under rx_reset", d, 8'h00);
        rx_reset = 0;
    endtask

    task automatic t_cts();
        logic [7:0] d;
        cts_in = 1; step(4);
        wr(5'h11, 8'h80);
        cts_in = 0; step(4);
        rd(5'h10, d); check("R6 cts fall without tx_enable", d, 8'h00);
        cts_in = 1; tx_enable = 1; step(4);
        cts_in = 0; step(4);
        rd(5'h10, d); check("R3 cts flag", d, 8'h80);
        cts_in = 1; step(4);
        rd(5'h10, d); check("R6 cts rise no change", d, 8'h90);
        cts_in = 0; step(4);
        tx_enable = 0;
        wr(5'h10, 8'h80);
        rd(5'h10, d); check("R7 cts clear", d, 8'h00);
        tx_drained = 1; step(1); tx_drained = 0;
    endtask

    task automatic t_dsr();
        logic [7:0] d;
        rx_reset = 1; dsr_in = 1; step(4);
        rd(5'h10, d); check("R6 dsr rise in rx reset", d, 8'h08);
        dsr_in = 0; step(4);
        rx_reset = 0; dsr_in = 1; step(4);
        rd(5'h10, d); check("R4 dsr flag", d, 8'h48);
        dsr_in = 0; step(4);
        rd(5'h10, d); check("R6 dsr fall keeps flag only", d, 8'h40);
        wr(5'h10, 8'h40);
        rd(5'h10, d); check("R7 dsr clear", d, 8'h00);
    endtask

    task automatic t_dcd();
        logic [7:0] d;
        dcd_in = 1; step(4);
        rd(5'h10, d); check("R6 dcd rise", d, 8'h04);
        dcd_in = 0; step(4);
        rd(5'h10, d); check("R5 dcd flag", d, 8'h20);
        wr(5'h10, 8'h00);
        rd(5'h10, d); check("R7 zero write keeps", d, 8'h20);
        wr(5'h10, 8'hC0);
        rd(5'h10, d); check("R7 other bits keep", d, 8'h20);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        step(1); check("R8 no enable no irq", irq, 0);
        wr(5'h15, 8'h20);
        step(1); check("R8 enabled irq", irq, 1);
        rd(5'h15, d); check("R8 ien readback", d, 8'h20);
        wr(5'h15, 8'hC0);
        step(1); check("R8 other enables", irq, 0);
        wr(5'h15, 8'hE0);
        step(1); check("R8 re-enabled", irq, 1);
        wr(5'h10, 8'h20);
        step(1); check("R8 cleared flag drops irq", irq, 0);
        wr(5'h15, 8'h00);
    endtask

    task automatic t_rts_dtr();
        logic [7:0] d;
        wr(5'h11, 8'h80);
        check("R9 rts asserted", rts_out, 1);
        rd(5'h11, d); check("R9 readback held", d, 8'h80);
        wr(5'h11, 8'h00);
        check("R9 software cannot drop", rts_out, 1);
        rd(5'h11, d); check("R9 readback still held", d, 8'h80);
        @(negedge clk); tx_drained = 1;
        @(negedge clk); tx_drained = 0;
        check("R10 drained releases", rts_out, 0);
        rd(5'h11, d); check("R10 bit cleared", d, 8'h00);
        wr(5'h11, 8'h40);
        check("R11 dtr high", dtr_out, 1);
        wr(5'h11, 8'h3F);
        check("R11 dtr low", dtr_out, 0);
        rd(5'h11, d); check("R11 low bits", d, 8'h3F);
    endtask

    task automatic t_unused();
        logic [7:0] d;
        wr(5'h12, 8'hFF);
        wr(5'h00, 8'hFF);
        rd(5'h12, d); check("R12 unused read", d, 8'h00);
        rd(5'h11, d); check("R12 ctrl untouched", d, 8'h3F);
        rd(5'h15, d); check("R12 ien untouched", d, 8'h00);
        check("R12 rts untouched", rts_out, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_levels();
        t_cts();
        t_dsr();
        t_dcd();
        t_irq();
        t_rts_dtr();
        t_unused();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule